// File: doc/BRIEF.md
# Address-Sequence Unlock Detector

This block watches the read and write cycles of an asynchronous SRAM-style memory bus, presented to it as synchronous strobes: a one-cycle pulse when a chip-enable-controlled read finishes (together with that read's address) and a one-cycle pulse when a write finishes. It looks for a fixed unlock pattern of six consecutive reads. The first five addresses are the same for both commands. The sixth address selects one of two commands: copy the volatile array into nonvolatile storage ("store") or copy it back the other way ("recall").

When the pattern completes, the detector raises a one-cycle command pulse for the nonvolatile engine. Any write, and any read that is not the next expected address, throws the pattern away. While the engine reports that it is busy, the detector ignores the bus and stays idle. The detector does not perform memory accesses and does not drive any output enable.

Top module: `seq_unlock_detector`

## Requirements
- R1: While `rst` is high at a clock edge, the detector clears: after that edge `step_cnt` is 0 and both command outputs are 0, even in the middle of a sequence.
- R2: Each read whose low 14 address bits equal the next prefix address advances `step_cnt` by one after the edge. The prefix addresses, in order, are 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, taking `step_cnt` from 0 up to 5.
- R3: When `step_cnt` is 5, a read of 0x0FC0 makes `store_cmd` 1 for exactly the next cycle and returns `step_cnt` to 0.
- R4: When `step_cnt` is 5, a read of 0x0C63 makes `recall_cmd` 1 for exactly the next cycle and returns `step_cnt` to 0.
- R5: Only address bits 13..0 are compared; bit 14 of `rd_addr` has no effect on matching.
- R6: A write strobe returns `step_cnt` to 0 and issues no command. If a write and a read strobe arrive in the same cycle, the write wins.
- R7: A read that does not match the next expected address returns `step_cnt` to 0. If that read's address is 0x0E38, `step_cnt` becomes 1 instead, because the read counts as the first step of a new sequence. This also applies when `step_cnt` is 5.
- R8: While `engine_busy` is high, strobes are ignored: `step_cnt` goes to 0 after the edge and no command is issued.
- R9: `store_cmd` and `recall_cmd` are never high together, and each appears only after a read accepted while `step_cnt` was 5.
- R10: `step_cnt` is a binary count of matched steps, from 0 (idle) to 5, and never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_done | input | 1 | One-cycle pulse: a chip-enable-controlled read has completed |
| wr_done | input | 1 | One-cycle pulse: a write has completed |
| rd_addr | input | 15 | Address of the completed read |
| engine_busy | input | 1 | Nonvolatile engine busy; the bus is not observed |
| store_cmd | output | 1 | One-cycle store command |
| recall_cmd | output | 1 | One-cycle recall command |
| step_cnt | output | 3 | Number of matched sequence steps (0..5) |

## Verification
The hardest states to reach are those at step 5, where one further read decides between store, recall, restart and abort. Reaching step 5 takes five exact reads in a row, and every one of those reads must escape the abort rules. The stimulus table builds the full prefix again before each step-5 outcome. It then drives that outcome in turn: the store address, the recall address with bit 14 set, the first prefix address (restart), and a read that arrives while the engine is busy. A write placed mid-sequence, followed by the read that would have been the next step, shows that the abort really discarded the progress.

// File: rtl/seq_unlock_pkg.sv
package seq_unlock_pkg;

    localparam int ADDR_W  = 15;
    localparam int CMP_W   = 14;
    localparam int SEQ_LEN = 6;
    localparam int STEP_W  = $clog2(SEQ_LEN);
    localparam int PRE_LEN = SEQ_LEN - 1;

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PRE_LEN);

    localparam logic [CMP_W-1:0] STORE_ADDR  = 14'h0FC0;
    localparam logic [CMP_W-1:0] RECALL_ADDR = 14'h0C63;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [CMP_W-1:0] addr;
    } bus_evt_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_ABORT,
        EV_ADVANCE,
        EV_RESTART,
        EV_STORE,
        EV_RECALL,
        EV_HOLD
    } seq_evt_e;

    function automatic logic [CMP_W-1:0] prefix_addr(input int idx);
        case (idx)
            0:       return 14'h0E38;
            1:       return 14'h31C7;
            2:       return 14'h03E0;
            3:       return 14'h3C1F;
            default: return 14'h303F;
        endcase
    endfunction

endpackage

// File: rtl/sud_addr_match.sv
module sud_addr_match
    import seq_unlock_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [CMP_W-1:0]  addr,
    output logic              hit_next,
    output logic              hit_first,
    output logic              hit_store,
    output logic              hit_recall
);
    logic [SEQ_LEN-1:0] hit_vec;

    for (genvar i = 0; i < SEQ_LEN; i++) begin : g_cmp
        if (i < PRE_LEN) begin : g_pre
            assign hit_vec[i] = (addr == prefix_addr(i));
        end else begin : g_tail
            assign hit_vec[i] = 1'b0;
        end
    end

    assign hit_next   = hit_vec[step];
    assign hit_first  = hit_vec[0];
    assign hit_store  = (addr == STORE_ADDR);
    assign hit_recall = (addr == RECALL_ADDR);

endmodule

// File: rtl/sud_step_fsm.sv
module sud_step_fsm
    import seq_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          acc,
    input  logic              busy,
    input  logic              hit_next,
    input  logic              hit_first,
    input  logic              hit_store,
    input  logic              hit_recall,
    output logic [STEP_W-1:0] step_q,
    output seq_evt_e          evt
);
    logic [STEP_W-1:0] step_d;

    always_comb begin
        evt = EV_NONE;
        if (busy) begin
            evt = EV_HOLD;
        end else if (acc.wr) begin
            evt = EV_ABORT;
        end else if (acc.rd) begin
            if (step_q == LAST_STEP) begin
                if (hit_store)       evt = EV_STORE;
                else if (hit_recall) evt = EV_RECALL;
                else if (hit_first)  evt = EV_RESTART;
                else                 evt = EV_ABORT;
            end else begin
                if (hit_next)        evt = EV_ADVANCE;
                else if (hit_first)  evt = EV_RESTART;
                else                 evt = EV_ABORT;
            end
        end
    end

    always_comb begin
        case (evt)
            EV_NONE:    step_d = step_q;
            EV_ADVANCE: step_d = step_q + STEP_W'(1);
            EV_RESTART: step_d = STEP_W'(1);
            default:    step_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end

    assert_step_range_R10: assert property (@(posedge clk) disable iff (rst)
        step_q <= LAST_STEP);

    assert_busy_idle_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (step_q == '0));

    assert_write_abort_R6: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && !busy) |=> (step_q == '0));

    assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && !acc.wr && !busy && step_q != LAST_STEP && hit_next)
        |=> (step_q == $past(step_q) + STEP_W'(1)));

endmodule

// File: rtl/sud_cmd_out.sv
module sud_cmd_out
    import seq_unlock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_evt_e evt,
    output logic     store_q,
    output logic     recall_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q  <= 1'b0;
            recall_q <= 1'b0;
        end else begin
            store_q  <= (evt == EV_STORE);
            recall_q <= (evt == EV_RECALL);
        end
    end

    assert_cmd_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(store_q && recall_q));

    assert_store_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        store_q |=> !store_q);

    assert_recall_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        recall_q |=> !recall_q);

endmodule

// File: rtl/seq_unlock_detector.sv
module seq_unlock_detector
    import seq_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_done,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              engine_busy,
    output logic              store_cmd,
    output logic              recall_cmd,
    output logic [STEP_W-1:0] step_cnt
);
    bus_evt_t acc;
    logic     hit_next, hit_first, hit_store, hit_recall;
    seq_evt_e evt;
    logic     unused_hi_bits;

    assign acc.rd   = rd_done;
    assign acc.wr   = wr_done;
    assign acc.addr = rd_addr[CMP_W-1:0];
    assign unused_hi_bits = ^rd_addr[ADDR_W-1:CMP_W];

    sud_addr_match u_match (
        .step       (step_cnt),
        .addr       (acc.addr),
        .hit_next   (hit_next),
        .hit_first  (hit_first),
        .hit_store  (hit_store),
        .hit_recall (hit_recall)
    );

    sud_step_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .busy       (engine_busy),
        .hit_next   (hit_next),
        .hit_first  (hit_first),
        .hit_store  (hit_store),
        .hit_recall (hit_recall),
        .step_q     (step_cnt),
        .evt        (evt)
    );

    sud_cmd_out u_cmd (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .store_q  (store_cmd),
        .recall_q (recall_cmd)
    );

    assert_store_source_R9: assert property (@(posedge clk) disable iff (rst)
        store_cmd |-> ($past(step_cnt) == LAST_STEP && $past(rd_done)
                       && !$past(engine_busy) && !$past(wr_done)));

    assert_recall_source_R9: assert property (@(posedge clk) disable iff (rst)
        recall_cmd |-> ($past(step_cnt) == LAST_STEP && $past(rd_done)
                        && !$past(engine_busy) && !$past(wr_done)));

endmodule

// File: tb/seq_unlock_detector_tb.sv
module seq_unlock_detector_tb;

    localparam int CLK_P  = 10;
    localparam int NVEC   = 40;

    localparam logic [1:0] K_IDLE = 2'd0;
    localparam logic [1:0] K_RD   = 2'd1;
    localparam logic [1:0] K_WR   = 2'd2;
    localparam logic [1:0] K_BUSY = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [14:0] addr;
        logic [2:0]  step;
        logic        st;
        logic        rc;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{K_RD,   15'h0E38, 3'd1, 1'b0, 1'b0, 4'd2},  // R2 step 1
        '{K_RD,   15'h31C7, 3'd2, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h03E0, 3'd3, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h3C1F, 3'd4, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h303F, 3'd5, 1'b0, 1'b0, 4'd2},  // R2 step 5
        '{K_RD,   15'h0FC0, 3'd0, 1'b1, 1'b0, 4'd3},  // R3 store
        '{K_IDLE, 15'h0000, 3'd0, 1'b0, 1'b0, 4'd9},  // R9 pulse ends
        '{K_RD,   15'h4E38, 3'd1, 1'b0, 1'b0, 4'd5},  // R5 bit 14 set
        '{K_RD,   15'h71C7, 3'd2, 1'b0, 1'b0, 4'd5},  // R5
        '{K_RD,   15'h03E0, 3'd3, 1'b0, 1'b0, 4'd5},  // R5
        '{K_RD,   15'h7C1F, 3'd4, 1'b0, 1'b0, 4'd5},  // R5
        '{K_RD,   15'h703F, 3'd5, 1'b0, 1'b0, 4'd5},  // R5
        '{K_RD,   15'h4C63, 3'd0, 1'b0, 1'b1, 4'd4},  // R4 recall, bit 14 set
        '{K_IDLE, 15'h0000, 3'd0, 1'b0, 1'b0, 4'd4},  // R4 pulse ends
        '{K_RD,   15'h0E38, 3'd1, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h31C7, 3'd2, 1'b0, 1'b0, 4'd2},  // R2
        '{K_WR,   15'h03E0, 3'd0, 1'b0, 1'b0, 4'd6},  // R6 write aborts
        '{K_RD,   15'h03E0, 3'd0, 1'b0, 1'b0, 4'd6},  // R6 progress lost
        '{K_RD,   15'h0E38, 3'd1, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h0E38, 3'd1, 1'b0, 1'b0, 4'd7},  // R7 restart on first addr
        '{K_RD,   15'h31C7, 3'd2, 1'b0, 1'b0, 4'd7},  // R7 continues after restart
        '{K_RD,   15'h1234, 3'd0, 1'b0, 1'b0, 4'd7},  // R7 mismatch aborts
        '{K_RD,   15'h0E38, 3'd1, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h31C7, 3'd2, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h03E0, 3'd3, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h3C1F, 3'd4, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h303F, 3'd5, 1'b0, 1'b0, 4'd10}, // R10 max count
        '{K_BUSY, 15'h0FC0, 3'd0, 1'b0, 1'b0, 4'd8},  // R8 busy: no store
        '{K_RD,   15'h0FC0, 3'd0, 1'b0, 1'b0, 4'd8},  // R8 sequence was lost
        '{K_RD,   15'h0E38, 3'd1, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h31C7, 3'd2, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h03E0, 3'd3, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h3C1F, 3'd4, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h303F, 3'd5, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h0E38, 3'd1, 1'b0, 1'b0, 4'd7},  // R7 restart from step 5
        '{K_RD,   15'h31C7, 3'd2, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h03E0, 3'd3, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h3C1F, 3'd4, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h303F, 3'd5, 1'b0, 1'b0, 4'd2},  // R2
        '{K_RD,   15'h0C63, 3'd0, 1'b0, 1'b1, 4'd4}   // R4 recall
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_done = 1'b0;
    logic        wr_done = 1'b0;
    logic [14:0] rd_addr = '0;
    logic        engine_busy = 1'b0;
    logic        store_cmd, recall_cmd;
    logic [2:0]  step_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    seq_unlock_detector u_dut (
        .clk         (clk),
        .rst         (rst),
        .rd_done     (rd_done),
        .wr_done     (wr_done),
        .rd_addr     (rd_addr),
        .engine_busy (engine_busy),
        .store_cmd   (store_cmd),
        .recall_cmd  (recall_cmd),
        .step_cnt    (step_cnt)
    );

    task automatic check(input string tag, input logic [2:0] e_step,
                         input logic e_st, input logic e_rc);
        n_chk++;
        if (step_cnt !== e_step || store_cmd !== e_st || recall_cmd !== e_rc) begin
            n_fail++;
            $display("FAIL %s: step=%0d store=%0b recall=%0b expected step=%0d store=%0b recall=%0b",
                     tag, step_cnt, store_cmd, recall_cmd, e_step, e_st, e_rc);
        end
    endtask

    // Drive one strobe for one cycle, sample 1 time unit after the edge.
    task automatic apply(input logic [1:0] kind, input logic [14:0] addr);
        @(negedge clk);
        rd_addr     = addr;
        rd_done     = (kind == K_RD) || (kind == K_BUSY);
        wr_done     = (kind == K_WR);
        engine_busy = (kind == K_BUSY);
        @(posedge clk);
        #1;
        rd_done     = 1'b0;
        wr_done     = 1'b0;
        engine_busy = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R10 idle after reset", 3'd0, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].kind, VECS[i].addr);
            check($sformatf("R%0d vec %0d", VECS[i].req, i),
                  VECS[i].step, VECS[i].st, VECS[i].rc);
        end

        // R1: reset in the middle of a sequence
        apply(K_RD, 15'h0E38);
        apply(K_RD, 15'h31C7);
        apply(K_RD, 15'h03E0);
        check("R1 pre-reset step", 3'd3, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-sequence reset", 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R6: write and read in the same cycle, write wins
        apply(K_RD, 15'h0E38);
        @(negedge clk);
        rd_addr = 15'h31C7;
        rd_done = 1'b1;
        wr_done = 1'b1;
        @(posedge clk);
        #1;
        rd_done = 1'b0;
        wr_done = 1'b0;
        check("R6 write beats read", 3'd0, 1'b0, 1'b0);

        // R3 store at the end, then no lingering pulse
        apply(K_RD, 15'h0E38);
        apply(K_RD, 15'h31C7);
        apply(K_RD, 15'h03E0);
        apply(K_RD, 15'h3C1F);
        apply(K_RD, 15'h303F);
        apply(K_RD, 15'h4FC0);
        check("R3 store with bit 14 set", 3'd0, 1'b1, 1'b0);
        apply(K_IDLE, 15'h0000);
        check("R3 store pulse one cycle", 3'd0, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule